// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This block resolves the source operand of a two-operand ALU instruction. A start pulse brings a 3-bit addressing-mode code, a base register index, a second register index and a signed constant field. The block reads two register-file ports combinationally, works out an effective address, and fetches from a word memory as many times as the mode requires: none, one or two sequential reads. When the operand is known it pulses `done_o` and presents the operand and the effective address. Those two values stay on the outputs until the next completion.

The modes range from the register contents and the constant itself, through base-plus-constant, register pointer, register-plus-register and absolute addressing, up to a pointer fetched from memory. One shared adder serves every address that needs a sum. Memory traffic uses a request/ready/valid read handshake with at most one read outstanding. The register indices pass straight through to the register file, and register contents are sampled on the start cycle only.

Top module: `operand_fetch_unit`

## Requirements
- R1: Mode code 0 returns the word read through the second register port as the operand, issues no memory request and reports an effective address of 0.
- R2: Mode code 1 returns the constant field, sign-extended from 16 to 32 bits, as the operand; no request is issued and the effective address is 0.
- R3: Mode code 2 reads one word at base register plus sign-extended constant, wrapping modulo 2^32, and returns that word with the address.
- R4: Mode code 3 reads one word at the address held in the base register.
- R5: Mode code 4 reads one word at base register plus second register, wrapping modulo 2^32.
- R6: Mode code 5 reads one word at the sign-extended constant used as an absolute address.
- R7: Mode code 6 first reads at the base register contents, then reads at the returned word. The second word is the operand, and the first returned word is reported as the effective address.
- R8: `mem_req_o` stays high with an unchanged `mem_addr_o` until a cycle with `mem_ready_i` high. Only one read is outstanding at a time. Read data is taken in the cycle `mem_valid_i` is high.
- R9: `done_o` is a one-cycle pulse. For modes 0, 1 and 7 it is high in the cycle after the start cycle. For the memory modes it is high in the cycle after the final read's `mem_valid_i` cycle.
- R10: Mode code 7 is reserved. It raises `err_o` together with `done_o` one cycle after start, with operand and address 0, and it never requests memory.
- R11: A start pulse while an operation is in progress has no effect on that operation and starts nothing new.
- R12: Synchronous active-high reset drops `done_o`, `err_o` and `mem_req_o` at the next edge, clears operand and address to 0, and abandons any operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin resolving an operand |
| mode_i | input | 3 | Addressing-mode code |
| ra_idx_i | input | 4 | Base register index |
| rb_idx_i | input | 4 | Second register index |
| const_i | input | 16 | Signed constant field |
| rf_ra_idx_o | output | 4 | Register-file index for the base port |
| rf_ra_data_i | input | 32 | Register-file data for the base port |
| rf_rb_idx_o | output | 4 | Register-file index for the second port |
| rf_rb_data_i | input | 32 | Register-file data for the second port |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_valid_i | input | 1 | Memory read data is valid |
| mem_rdata_i | input | 32 | Memory read data |
| done_o | output | 1 | Operand resolved (one-cycle pulse) |
| err_o | output | 1 | Reserved mode seen, with done |
| operand_o | output | 32 | Resolved operand |
| ea_o | output | 32 | Effective address of the final read |

## Verification
Register and constant modes, and the reserved code, must show `done_o` in the cycle right after the start cycle. The bench records the cycle counter at the falling edge where it raises start and expects the completion one count later. For the memory modes the memory model stamps the cycle in which it shows `mem_valid_i`, and completion must fall exactly one cycle after that stamp. The following falling edge must show `done_o` low again. All outputs are sampled on falling edges only, and the memory model varies its ready and valid latencies from vector to vector, so that a result arriving one cycle early or late is caught.

// File: rtl/opf_pkg.sv
package opf_pkg;

   typedef enum logic [2:0] {
      M_REG    = 3'd0,
      M_IMM    = 3'd1,
      M_DISP   = 3'd2,
      M_DEFER  = 3'd3,
      M_INDEX  = 3'd4,
      M_DIRECT = 3'd5,
      M_INDIR  = 3'd6,
      M_RSVD   = 3'd7
   } amode_e;

   // how many memory reads a mode needs
   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_ONE  = 2'd1,
      K_TWO  = 2'd2,
      K_BAD  = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_PTR   = 2'd1,
      S_FINAL = 2'd2
   } seq_e;

endpackage

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
   import opf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CONST_W  = 16,
   parameter bit SIGN_EXT = 1'b1
) (
   input  amode_e              mode_i,
   input  logic [DATA_W-1:0]   base_i,
   input  logic [DATA_W-1:0]   index_i,
   input  logic [CONST_W-1:0]  const_i,
   output kind_e               kind_o,
   output logic [DATA_W-1:0]   ea_o,
   output logic [DATA_W-1:0]   value_o
);

   localparam int PAD_W = DATA_W - CONST_W;

   if (CONST_W < 2 || CONST_W >= DATA_W) begin : g_bad_const
      $error("opf_ea_calc: CONST_W must lie in 2..DATA_W-1");
   end

   logic [DATA_W-1:0] cext;
   logic [DATA_W-1:0] addend;
   logic [DATA_W-1:0] sum;

   // extension variant chosen at elaboration
   if (SIGN_EXT) begin : g_sext
      assign cext = {{PAD_W{const_i[CONST_W-1]}}, const_i};
   end else begin : g_zext
      assign cext = {{PAD_W{1'b0}}, const_i};
   end

   // single adder: second operand picked by mode, wraps at DATA_W bits
   assign addend = (mode_i == M_INDEX) ? index_i : cext;
   assign sum    = base_i + addend;

   always_comb begin
      kind_o  = K_BAD;
      ea_o    = '0;
      value_o = '0;
      unique case (mode_i)
         M_REG: begin
            kind_o  = K_NONE;
            value_o = index_i;
         end
         M_IMM: begin
            kind_o  = K_NONE;
            value_o = cext;
         end
         M_DISP: begin
            kind_o = K_ONE;
            ea_o   = sum;
         end
         M_DEFER: begin
            kind_o = K_ONE;
            ea_o   = base_i;
         end
         M_INDEX: begin
            kind_o = K_ONE;
            ea_o   = sum;
         end
         M_DIRECT: begin
            kind_o = K_ONE;
            ea_o   = cext;
         end
         M_INDIR: begin
            kind_o = K_TWO;
            ea_o   = base_i;
         end
         default: begin
            kind_o = K_BAD;
         end
      endcase
   end

endmodule

// File: rtl/opf_rd_port.sv
module opf_rd_port #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              issue_i,
   input  logic [ADDR_W-1:0] issue_addr_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_ready_i,
   input  logic              mem_valid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              rsp_fire_o,
   output logic [DATA_W-1:0] rsp_data_o
);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
      $error("opf_rd_port: widths must be positive");
   end

   logic              req_q;
   logic              pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic              accept;

   assign accept     = req_q & mem_ready_i;
   assign rsp_fire_o = mem_valid_i & (pend_q | accept);
   assign rsp_data_o = mem_rdata_i;
   assign mem_req_o  = req_q;
   assign mem_addr_o = addr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q  <= 1'b0;
         pend_q <= 1'b0;
         addr_q <= '0;
      end else begin
         if (accept) begin
            req_q  <= 1'b0;
            pend_q <= 1'b1;
         end
         if (rsp_fire_o) begin
            pend_q <= 1'b0;
         end
         if (issue_i) begin
            req_q  <= 1'b1;
            addr_q <= issue_addr_i;
         end
      end
   end

   // R8: request held with a steady address until accepted
   a_r8_req_held : assert property (@(posedge clk) disable iff (rst)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R8: a new read is only issued once the previous one has completed
   a_r8_one_outstanding : assert property (@(posedge clk) disable iff (rst)
      issue_i |-> (!req_q && (!pend_q || rsp_fire_o)));

endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
   import opf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  kind_e             kind_i,
   input  logic [DATA_W-1:0] ea_i,
   input  logic [DATA_W-1:0] value_i,
   output logic              issue_o,
   output logic [DATA_W-1:0] issue_addr_o,
   input  logic              rsp_fire_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [DATA_W-1:0] operand_o,
   output logic [DATA_W-1:0] ea_o
);

   seq_e              state_q;
   logic [DATA_W-1:0] ea_q;
   logic              launch;

   assign busy_o = (state_q != S_IDLE);
   assign launch = (state_q == S_IDLE) && start_i;

   assign issue_o = (launch && (kind_i == K_ONE || kind_i == K_TWO))
                 || (state_q == S_PTR && rsp_fire_i);
   assign issue_addr_o = (state_q == S_PTR) ? rsp_data_i : ea_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= S_IDLE;
         ea_q      <= '0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
         operand_o <= '0;
         ea_o      <= '0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start_i) begin
                  unique case (kind_i)
                     K_NONE: begin
                        done_o    <= 1'b1;
                        operand_o <= value_i;
                        ea_o      <= '0;
                     end
                     K_ONE: begin
                        ea_q    <= ea_i;
                        state_q <= S_FINAL;
                     end
                     K_TWO: begin
                        state_q <= S_PTR;
                     end
                     default: begin
                        done_o    <= 1'b1;
                        err_o     <= 1'b1;
                        operand_o <= '0;
                        ea_o      <= '0;
                     end
                  endcase
               end
            end
            S_PTR: begin
               if (rsp_fire_i) begin
                  ea_q    <= rsp_data_i;
                  state_q <= S_FINAL;
               end
            end
            S_FINAL: begin
               if (rsp_fire_i) begin
                  done_o    <= 1'b1;
                  operand_o <= rsp_data_i;
                  ea_o      <= ea_q;
                  state_q   <= S_IDLE;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R11: while busy, a start never launches a fresh read
   a_r11_busy_no_launch : assert property (@(posedge clk) disable iff (rst)
      (busy_o && start_i && !rsp_fire_i) |-> !issue_o);

   // R7: the pointer read of mode 6 is followed by a final read, not completion
   a_r7_two_reads : assert property (@(posedge clk) disable iff (rst)
      (state_q == S_PTR && rsp_fire_i) |=> (!done_o && state_q == S_FINAL));

endmodule

// File: rtl/operand_fetch_unit.sv
module operand_fetch_unit
   import opf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int REG_IDX_W  = 4,
   parameter int CONST_W    = 16,
   parameter bit SIGN_CONST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start_i,
   input  logic [2:0]           mode_i,
   input  logic [REG_IDX_W-1:0] ra_idx_i,
   input  logic [REG_IDX_W-1:0] rb_idx_i,
   input  logic [CONST_W-1:0]   const_i,
   output logic [REG_IDX_W-1:0] rf_ra_idx_o,
   input  logic [DATA_W-1:0]    rf_ra_data_i,
   output logic [REG_IDX_W-1:0] rf_rb_idx_o,
   input  logic [DATA_W-1:0]    rf_rb_data_i,
   output logic                 mem_req_o,
   output logic [DATA_W-1:0]    mem_addr_o,
   input  logic                 mem_ready_i,
   input  logic                 mem_valid_i,
   input  logic [DATA_W-1:0]    mem_rdata_i,
   output logic                 done_o,
   output logic                 err_o,
   output logic [DATA_W-1:0]    operand_o,
   output logic [DATA_W-1:0]    ea_o
);

   localparam int ADDR_W = DATA_W;

   if (DATA_W < 8) begin : g_bad_data
      $error("operand_fetch_unit: DATA_W must be at least 8");
   end
   if (REG_IDX_W < 1 || REG_IDX_W > 8) begin : g_bad_idx
      $error("operand_fetch_unit: REG_IDX_W must lie in 1..8");
   end

   amode_e            mode;
   kind_e             kind;
   logic [DATA_W-1:0] ea_calc;
   logic [DATA_W-1:0] value_calc;
   logic              issue;
   logic [ADDR_W-1:0] issue_addr;
   logic              rsp_fire;
   logic [DATA_W-1:0] rsp_data;
   logic              busy;

   assign mode        = amode_e'(mode_i);
   assign rf_ra_idx_o = ra_idx_i;
   assign rf_rb_idx_o = rb_idx_i;

   opf_ea_calc #(
      .DATA_W   (DATA_W),
      .CONST_W  (CONST_W),
      .SIGN_EXT (SIGN_CONST)
   ) ea_i (
      .mode_i  (mode),
      .base_i  (rf_ra_data_i),
      .index_i (rf_rb_data_i),
      .const_i (const_i),
      .kind_o  (kind),
      .ea_o    (ea_calc),
      .value_o (value_calc)
   );

   opf_ctrl #(
      .DATA_W (DATA_W)
   ) ctrl_i (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start_i),
      .kind_i       (kind),
      .ea_i         (ea_calc),
      .value_i      (value_calc),
      .issue_o      (issue),
      .issue_addr_o (issue_addr),
      .rsp_fire_i   (rsp_fire),
      .rsp_data_i   (rsp_data),
      .busy_o       (busy),
      .done_o       (done_o),
      .err_o        (err_o),
      .operand_o    (operand_o),
      .ea_o         (ea_o)
   );

   opf_rd_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) port_i (
      .clk          (clk),
      .rst          (rst),
      .issue_i      (issue),
      .issue_addr_i (issue_addr),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .mem_ready_i  (mem_ready_i),
      .mem_valid_i  (mem_valid_i),
      .mem_rdata_i  (mem_rdata_i),
      .rsp_fire_o   (rsp_fire),
      .rsp_data_o   (rsp_data)
   );

   // R9: memory-free modes complete one cycle after start without a request
   a_r9_nomem_done : assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy && (mode_i == 3'd0 || mode_i == 3'd1))
      |=> (done_o && !err_o && !mem_req_o));

   // R9: completion is a single-cycle pulse
   a_r9_done_pulse : assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   // R10: reserved code flags an error with done and leaves memory alone
   a_r10_reserved : assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy && mode_i == 3'd7) |=> (done_o && err_o && !mem_req_o));

   // R10: error never appears without done
   a_r10_err_with_done : assert property (@(posedge clk) disable iff (rst)
      err_o |-> done_o);

   // R12: reset quiets all handshake and result strobes
   a_r12_reset_quiet : assert property (@(posedge clk)
      rst |=> (!done_o && !err_o && !mem_req_o));

endmodule

// File: tb/operand_fetch_unit_tb_top.sv
module operand_fetch_unit_tb_top;

   typedef struct packed {
      logic [2:0]  md;
      logic [3:0]  ra;
      logic [3:0]  rb;
      logic [15:0] c;
      logic [1:0]  nrd;   // reads expected
      logic [31:0] a0;    // first read address
      logic [31:0] op;    // operand when no read
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 4'd1, 4'd5, 16'h0000, 2'd0, 32'h0,          32'h0000_1234},
      '{3'd1, 4'd0, 4'd0, 16'h0005, 2'd0, 32'h0,          32'h0000_0005},
      '{3'd1, 4'd0, 4'd0, 16'hFFFE, 2'd0, 32'h0,          32'hFFFF_FFFE},
      '{3'd2, 4'd1, 4'd0, 16'h0004, 2'd1, 32'd404,        32'h0},
      '{3'd2, 4'd1, 4'd0, 16'hFFFC, 2'd1, 32'd396,        32'h0},
      '{3'd2, 4'd6, 4'd0, 16'h0001, 2'd1, 32'h8000_0000,  32'h0},
      '{3'd2, 4'd4, 4'd0, 16'h0020, 2'd1, 32'h0000_0010,  32'h0},
      '{3'd3, 4'd1, 4'd9, 16'h7777, 2'd1, 32'd400,        32'h0},
      '{3'd4, 4'd2, 4'd3, 16'h0000, 2'd1, 32'd19,         32'h0},
      '{3'd4, 4'd4, 4'd6, 16'h0000, 2'd1, 32'h7FFF_FFEF,  32'h0},
      '{3'd5, 4'd1, 4'd1, 16'h1001, 2'd1, 32'h0000_1001,  32'h0},
      '{3'd5, 4'd0, 4'd0, 16'h8000, 2'd1, 32'hFFFF_8000,  32'h0},
      '{3'd6, 4'd1, 4'd0, 16'h0000, 2'd2, 32'd400,        32'h0},
      '{3'd6, 4'd5, 4'd0, 16'h0000, 2'd2, 32'h0000_1234,  32'h0},
      '{3'd7, 4'd1, 4'd2, 16'h0044, 2'd0, 32'h0,          32'h0}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start_i = 1'b0;
   logic [2:0]  mode_i = 3'd0;
   logic [3:0]  ra_idx_i = 4'd0;
   logic [3:0]  rb_idx_i = 4'd0;
   logic [15:0] const_i = 16'd0;
   logic [3:0]  rf_ra_idx_o, rf_rb_idx_o;
   logic [31:0] rf_ra_data_i, rf_rb_data_i;
   logic        mem_req_o;
   logic [31:0] mem_addr_o;
   logic        mem_ready_i = 1'b0;
   logic        mem_valid_i = 1'b0;
   logic [31:0] mem_rdata_i = 32'd0;
   logic        done_o, err_o;
   logic [31:0] operand_o, ea_o;

   logic [31:0] regs [16];

   int checks = 0;
   int fails  = 0;
   int cyc = 0;
   int vcyc = 0;
   int rdy_lat = 0;
   int vld_lat = 0;
   int rcnt = 0;
   int vcnt = 0;
   int req_count = 0;
   int stab_err = 0;
   logic        pend = 1'b0;
   logic        seen = 1'b0;
   logic [31:0] pend_addr = 32'd0;
   logic [31:0] hold_addr = 32'd0;
   logic [31:0] hs_addr [64];

   always #2 clk = ~clk;   // 250 MHz

   assign rf_ra_data_i = regs[rf_ra_idx_o];
   assign rf_rb_data_i = regs[rf_rb_idx_o];

   operand_fetch_unit dut_i (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start_i),
      .mode_i       (mode_i),
      .ra_idx_i     (ra_idx_i),
      .rb_idx_i     (rb_idx_i),
      .const_i      (const_i),
      .rf_ra_idx_o  (rf_ra_idx_o),
      .rf_ra_data_i (rf_ra_data_i),
      .rf_rb_idx_o  (rf_rb_idx_o),
      .rf_rb_data_i (rf_rb_data_i),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .mem_ready_i  (mem_ready_i),
      .mem_valid_i  (mem_valid_i),
      .mem_rdata_i  (mem_rdata_i),
      .done_o       (done_o),
      .err_o        (err_o),
      .operand_o    (operand_o),
      .ea_o         (ea_o)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
   endfunction

   function automatic string tag_of(input logic [2:0] m);
      case (m)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         3'd6: return "R7";
         default: return "R10";
      endcase
   endfunction

   // memory model with adjustable ready and valid latency
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst) begin
         mem_ready_i <= 1'b0;
         mem_valid_i <= 1'b0;
         pend        <= 1'b0;
         seen        <= 1'b0;
         rcnt        <= 0;
      end else begin
         mem_valid_i <= 1'b0;
         if (mem_req_o) begin
            if (!seen) begin
               seen      <= 1'b1;
               hold_addr <= mem_addr_o;
            end else if (mem_addr_o !== hold_addr) begin
               stab_err <= stab_err + 1;
            end
            if (mem_ready_i) begin
               mem_ready_i <= 1'b0;
               seen        <= 1'b0;
               pend        <= 1'b1;
               pend_addr   <= mem_addr_o;
               vcnt        <= vld_lat;
               rcnt        <= 0;
               hs_addr[req_count % 64] <= mem_addr_o;
               req_count   <= req_count + 1;
            end else if (rcnt >= rdy_lat) begin
               mem_ready_i <= 1'b1;
            end else begin
               rcnt <= rcnt + 1;
            end
         end
         if (pend) begin
            if (vcnt == 0) begin
               mem_valid_i <= 1'b1;
               mem_rdata_i <= mem_word(pend_addr);
               pend        <= 1'b0;
               vcyc        <= cyc + 1;
            end else begin
               vcnt <= vcnt - 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int n0, c0, k;
      logic [31:0] exp_ea, exp_op;
      string t;
      t = tag_of(v.md);
      rdy_lat = idx % 3;
      vld_lat = (idx * 2) % 3;
      @(negedge clk);
      n0 = req_count;
      mode_i = v.md; ra_idx_i = v.ra; rb_idx_i = v.rb; const_i = v.c;
      start_i = 1'b1;
      c0 = cyc;
      @(negedge clk);
      start_i = 1'b0;
      k = 0;
      while (!done_o && k < 200) begin
         @(negedge clk);
         k++;
      end
      chk(done_o, t, "completion seen", {31'd0, done_o}, 32'd1);
      if (v.nrd == 2'd0) begin
         exp_ea = 32'd0;
         exp_op = v.op;
      end else if (v.nrd == 2'd1) begin
         exp_ea = v.a0;
         exp_op = mem_word(v.a0);
      end else begin
         exp_ea = mem_word(v.a0);
         exp_op = mem_word(exp_ea);
      end
      chk(operand_o == exp_op, t, "operand", operand_o, exp_op);
      chk(ea_o == exp_ea, t, "effective address", ea_o, exp_ea);
      chk(err_o == (v.md == 3'd7), t, "error flag", {31'd0, err_o},
          {31'd0, (v.md == 3'd7)});
      chk(req_count - n0 == int'(v.nrd), t, "read count", req_count - n0,
          {30'd0, v.nrd});
      if (v.nrd >= 2'd1)
         chk(hs_addr[n0 % 64] == v.a0, t, "first read address", hs_addr[n0 % 64], v.a0);
      if (v.nrd == 2'd2)
         chk(hs_addr[(n0 + 1) % 64] == exp_ea, "R7", "pointer read address",
             hs_addr[(n0 + 1) % 64], exp_ea);
      if (v.nrd == 2'd0)
         chk(cyc == c0 + 1, "R9", "done one cycle after start", cyc, c0 + 1);
      else
         chk(cyc == vcyc + 1, "R9", "done one cycle after final valid", cyc, vcyc + 1);
      @(negedge clk);
      chk(!done_o, "R9", "done is a single pulse", {31'd0, done_o}, 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) regs[i] = 32'hA000_0000 + i;
      regs[1] = 32'd400;
      regs[2] = 32'd16;
      regs[3] = 32'd3;
      regs[4] = 32'hFFFF_FFF0;
      regs[5] = 32'h0000_1234;
      regs[6] = 32'h7FFF_FFFF;
      for (int i = 0; i < 64; i++) hs_addr[i] = 32'd0;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R12: state after reset
      chk(!done_o && !err_o, "R12", "done/err after reset", {30'd0, done_o, err_o}, 32'd0);
      chk(!mem_req_o, "R12", "no request after reset", {31'd0, mem_req_o}, 32'd0);
      chk(operand_o == 32'd0 && ea_o == 32'd0, "R12", "outputs cleared", operand_o, 32'd0);

      for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

      // R11: start while busy is ignored
      begin
         int n0, k;
         rdy_lat = 4;
         vld_lat = 2;
         @(negedge clk);
         n0 = req_count;
         mode_i = 3'd3; ra_idx_i = 4'd2; rb_idx_i = 4'd5; const_i = 16'd0;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         @(negedge clk);
         mode_i = 3'd0; ra_idx_i = 4'd1;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         chk(!done_o, "R11", "no completion from busy start", {31'd0, done_o}, 32'd0);
         k = 0;
         while (!done_o && k < 200) begin
            @(negedge clk);
            k++;
         end
         chk(operand_o == mem_word(32'd16), "R11", "busy start left operand alone",
             operand_o, mem_word(32'd16));
         chk(req_count - n0 == 1, "R11", "single read only", req_count - n0, 32'd1);
         k = 0;
         for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (done_o) k++;
         end
         chk(k == 0, "R11", "no later completion", k, 32'd0);
      end

      // R8: address stability seen by the memory model
      chk(stab_err == 0, "R8", "address changes while waiting", stab_err, 32'd0);

      // R12: reset in the middle of an indirect fetch
      begin
         rdy_lat = 3;
         vld_lat = 1;
         @(negedge clk);
         mode_i = 3'd6; ra_idx_i = 4'd1;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         @(negedge clk);
         chk(mem_req_o, "R12", "request pending before reset", {31'd0, mem_req_o}, 32'd1);
         rst = 1'b1;
         @(negedge clk);
         rst = 1'b0;
         chk(!mem_req_o && !done_o && !err_o, "R12", "reset abandons fetch",
             {29'd0, mem_req_o, done_o, err_o}, 32'd0);
         chk(operand_o == 32'd0 && ea_o == 32'd0, "R12", "reset clears results",
             ea_o, 32'd0);
         for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            if (done_o || mem_req_o)
               chk(1'b0, "R12", "activity after reset", {30'd0, done_o, mem_req_o}, 32'd0);
         end
         run_vec(VEC[8], 1);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule